// File: doc/BRIEF.md
# Trap Entry Redirect Unit

This unit takes over at the moment a trap is raised. A one-cycle strobe comes in with the trap cause, the PC of the trapping instruction and the trap value. The unit chooses where the trap is handled:

- supervisor mode, when delegated;
- machine mode, with optional per-cause vectoring for interrupts;
- debug mode, for an enabled breakpoint;
- one of two fixed debug addresses, when the hart is already halted in debug.

It then registers the new PC and privilege. It also registers the cause, EPC and trap-value copies and the interrupt-enable stack bits of the mode that takes the trap.

The current privilege, the debug flag, the breakpoint enables, both delegation masks, both trap vectors and the live interrupt-enable bits are inputs supplied by the surrounding CSR file. Every field the unit writes is held in its own output register until the next trap writes that field. Decoding which event raised the trap happens upstream.

Top module: `trap_redirect`

## Requirements
- R1: While `dbg_mode_i` is high, a trap with cause 3 (MSB clear) loads `pc_o` with `DBG_ENTRY_ADDR`, and any other trap loads `DBG_EXC_ADDR`. No cause, EPC, tval, debug-save, status or privilege output changes, and `target_o` reads 3.
- R2: Outside debug, cause 3 with MSB clear is a breakpoint. When the `ebreak_en_i` bit for the current privilege is set (bit 2 = M, bit 1 = S, bit 0 = U), the unit enters debug. It sets `dcause_o`=1, `dprv_o`=current privilege, `dpc_o`=`epc_i`, `priv_o`=M (3), `pc_o`=`DBG_ENTRY_ADDR` and `target_o`=2. With the enable bit clear, the breakpoint is handled as an ordinary trap.
- R3: Cause MSB set marks an interrupt. The delegation bit is read from `irq_deleg_i` for interrupts and from `exc_deleg_i` for exceptions, at the position given by the cause with its MSB removed. An index of 32 or more is never delegated.
- R4: A trap goes to S mode only when the current privilege is U (0) or S (1) and the delegation bit is set. From M (3) it always lands in M.
- R5: S-mode entry sets `pc_o`=`stvec_i` and `priv_o`=1. It writes `scause_o`, `sepc_o` and `stval_o` from the trap inputs, sets `spie_o`=`sie_i` and `spp_o`=bit 0 of the old privilege, clears `sie_o`, and reports `target_o`=0.
- R6: M-mode entry sets `pc_o` to `mtvec_i` with bit 0 cleared. When `mtvec_i[0]` is set and the trap is an interrupt, it adds 4×index. It writes `mcause_o`, `mepc_o` and `mtval_o`, sets `mpie_o`=`mie_i` and `mpp_o`=old privilege, clears `mie_o`, sets `priv_o`=3, and reports `target_o`=1.
- R7: After reset, `pc_o`=`RESET_ADDR`, `priv_o`=3, `redirect_valid_o`=0, and all cause, EPC, tval, debug-save and status outputs are 0.
- R8: All outputs update on the clock edge where `trap_valid_i` is high. `redirect_valid_o` is high for exactly the following cycle. With the strobe low, every output holds its value regardless of the other inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trap_valid_i | input | 1 | Trap strobe |
| cause_i | input | 32 | Trap cause, MSB = interrupt |
| epc_i | input | 32 | PC of trapping instruction |
| tval_i | input | 32 | Trap value |
| cur_priv_i | input | 2 | Current privilege (0 U, 1 S, 3 M) |
| dbg_mode_i | input | 1 | Hart already in debug mode |
| ebreak_en_i | input | 3 | Breakpoint-to-debug enables {M,S,U} |
| irq_deleg_i | input | 32 | Interrupt delegation mask |
| exc_deleg_i | input | 32 | Exception delegation mask |
| stvec_i | input | 32 | S-mode trap vector |
| mtvec_i | input | 32 | M-mode trap vector, bit 0 = vectored |
| sie_i | input | 1 | Current S interrupt enable |
| mie_i | input | 1 | Current M interrupt enable |
| redirect_valid_o | output | 1 | New PC valid this cycle |
| target_o | output | 2 | 0 S, 1 M, 2 debug entry, 3 in-debug trap |
| pc_o | output | 32 | Redirect PC |
| priv_o | output | 2 | New privilege |
| mcause_o | output | 32 | M cause |
| mepc_o | output | 32 | M EPC |
| mtval_o | output | 32 | M trap value |
| scause_o | output | 32 | S cause |
| sepc_o | output | 32 | S EPC |
| stval_o | output | 32 | S trap value |
| dpc_o | output | 32 | Saved PC on debug entry |
| dprv_o | output | 2 | Saved privilege on debug entry |
| dcause_o | output | 3 | Debug entry cause |
| sie_o | output | 1 | S interrupt enable |
| spie_o | output | 1 | S previous interrupt enable |
| spp_o | output | 1 | S previous privilege |
| mie_o | output | 1 | M interrupt enable |
| mpie_o | output | 1 | M previous interrupt enable |
| mpp_o | output | 2 | M previous privilege |

## Verification
The bench builds the unit with `DBG_ENTRY_ADDR`=0x800, `DBG_EXC_ADDR`=0x808 and `RESET_ADDR`=0x1000. Because the three addresses are distinct, a swap between the breakpoint and non-breakpoint paths in debug, or a stray reset PC, shows up directly in `pc_o`. With the 32-bit cause, a cause index of 64 can be driven under an all-ones exception mask, which exposes any aliasing of large indices onto low delegation bits. An interrupt whose index equals the breakpoint code, issued with every breakpoint enable set, separates the interrupt flag from the breakpoint test.

// File: rtl/trap_redirect_pkg.sv
package trap_redirect_pkg;
    localparam int XLEN = 32;
    localparam int IDXW = $clog2(XLEN);
    localparam logic [1:0] PRIV_U = 2'd0;
    localparam logic [1:0] PRIV_S = 2'd1;
    localparam logic [1:0] PRIV_M = 2'd3;
    localparam int BP_CODE = 3;
    localparam logic [2:0] DCAUSE_SWBP = 3'd1;

    typedef enum logic [1:0] {
        TGT_S         = 2'd0,
        TGT_M         = 2'd1,
        TGT_DBG_ENTER = 2'd2,
        TGT_DBG_STAY  = 2'd3
    } tgt_e;

    typedef struct packed {
        logic            valid;
        tgt_e            tgt;
        logic [XLEN-1:0] pc;
        logic [1:0]      priv;
        logic [XLEN-1:0] mcause;
        logic [XLEN-1:0] mepc;
        logic [XLEN-1:0] mtval;
        logic [XLEN-1:0] scause;
        logic [XLEN-1:0] sepc;
        logic [XLEN-1:0] stval;
        logic [XLEN-1:0] dpc;
        logic [1:0]      dprv;
        logic [2:0]      dcause;
        logic            sie;
        logic            spie;
        logic            spp;
        logic            mie;
        logic            mpie;
        logic [1:0]      mpp;
    } redir_state_t;
endpackage

// File: rtl/trap_route.sv
module trap_route
    import trap_redirect_pkg::*;
(
    input  logic [XLEN-1:0] cause_i,
    input  logic [1:0]      priv_i,
    input  logic            dbg_mode_i,
    input  logic [2:0]      ebreak_en_i,
    input  logic [XLEN-1:0] irq_deleg_i,
    input  logic [XLEN-1:0] exc_deleg_i,
    output tgt_e            tgt_o,
    output logic            is_irq_o,
    output logic            is_bp_o,
    output logic [XLEN-2:0] idx_o
);
    logic            bp_en;
    logic [XLEN-1:0] mask;
    logic            low_priv;
    logic            in_range;
    logic            deleg_hit;

    always_comb begin
        is_irq_o = cause_i[XLEN-1];
        idx_o    = cause_i[XLEN-2:0];
        is_bp_o  = !is_irq_o && (idx_o == (XLEN-1)'(BP_CODE));
        case (priv_i)
            PRIV_M:  bp_en = ebreak_en_i[2];
            PRIV_S:  bp_en = ebreak_en_i[1];
            PRIV_U:  bp_en = ebreak_en_i[0];
            default: bp_en = 1'b0;
        endcase
        mask      = is_irq_o ? irq_deleg_i : exc_deleg_i;
        low_priv  = (priv_i == PRIV_U) || (priv_i == PRIV_S);
        in_range  = (idx_o[XLEN-2:IDXW] == '0);
        deleg_hit = mask[idx_o[IDXW-1:0]];

        if (dbg_mode_i)
            tgt_o = TGT_DBG_STAY;
        else if (is_bp_o && bp_en)
            tgt_o = TGT_DBG_ENTER;
        else if (low_priv && in_range && deleg_hit)
            tgt_o = TGT_S;
        else
            tgt_o = TGT_M;
    end
endmodule

// File: rtl/trap_target_pc.sv
module trap_target_pc
    import trap_redirect_pkg::*;
#(
    parameter logic [XLEN-1:0] DBG_ENTRY_ADDR = 32'h0000_0800,
    parameter logic [XLEN-1:0] DBG_EXC_ADDR   = 32'h0000_0808
) (
    input  tgt_e            tgt_i,
    input  logic            is_irq_i,
    input  logic            is_bp_i,
    input  logic [XLEN-2:0] idx_i,
    input  logic [XLEN-1:0] stvec_i,
    input  logic [XLEN-1:0] mtvec_i,
    output logic [XLEN-1:0] pc_o
);
    logic [XLEN-1:0] m_base;
    logic [XLEN-1:0] m_off;

    always_comb begin
        m_base = {mtvec_i[XLEN-1:1], 1'b0};
        m_off  = (mtvec_i[0] && is_irq_i) ? (XLEN'(idx_i) << 2) : '0;
        case (tgt_i)
            TGT_S:         pc_o = stvec_i;
            TGT_M:         pc_o = m_base + m_off;
            TGT_DBG_ENTER: pc_o = DBG_ENTRY_ADDR;
            default:       pc_o = is_bp_i ? DBG_ENTRY_ADDR : DBG_EXC_ADDR;
        endcase
    end
endmodule

// File: rtl/trap_redirect.sv
module trap_redirect
    import trap_redirect_pkg::*;
#(
    parameter logic [31:0] DBG_ENTRY_ADDR = 32'h0000_0800,
    parameter logic [31:0] DBG_EXC_ADDR   = 32'h0000_0808,
    parameter logic [31:0] RESET_ADDR     = 32'h0000_1000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        trap_valid_i,
    input  logic [31:0] cause_i,
    input  logic [31:0] epc_i,
    input  logic [31:0] tval_i,
    input  logic [1:0]  cur_priv_i,
    input  logic        dbg_mode_i,
    input  logic [2:0]  ebreak_en_i,
    input  logic [31:0] irq_deleg_i,
    input  logic [31:0] exc_deleg_i,
    input  logic [31:0] stvec_i,
    input  logic [31:0] mtvec_i,
    input  logic        sie_i,
    input  logic        mie_i,
    output logic        redirect_valid_o,
    output logic [1:0]  target_o,
    output logic [31:0] pc_o,
    output logic [1:0]  priv_o,
    output logic [31:0] mcause_o,
    output logic [31:0] mepc_o,
    output logic [31:0] mtval_o,
    output logic [31:0] scause_o,
    output logic [31:0] sepc_o,
    output logic [31:0] stval_o,
    output logic [31:0] dpc_o,
    output logic [1:0]  dprv_o,
    output logic [2:0]  dcause_o,
    output logic        sie_o,
    output logic        spie_o,
    output logic        spp_o,
    output logic        mie_o,
    output logic        mpie_o,
    output logic [1:0]  mpp_o
);
    tgt_e            route;
    logic            is_irq;
    logic            is_bp;
    logic [XLEN-2:0] idx;
    logic [XLEN-1:0] new_pc;
    redir_state_t    st_d, st_q;

    trap_route u_route (
        .cause_i     (cause_i),
        .priv_i      (cur_priv_i),
        .dbg_mode_i  (dbg_mode_i),
        .ebreak_en_i (ebreak_en_i),
        .irq_deleg_i (irq_deleg_i),
        .exc_deleg_i (exc_deleg_i),
        .tgt_o       (route),
        .is_irq_o    (is_irq),
        .is_bp_o     (is_bp),
        .idx_o       (idx)
    );

    trap_target_pc #(
        .DBG_ENTRY_ADDR (DBG_ENTRY_ADDR),
        .DBG_EXC_ADDR   (DBG_EXC_ADDR)
    ) u_pc (
        .tgt_i    (route),
        .is_irq_i (is_irq),
        .is_bp_i  (is_bp),
        .idx_i    (idx),
        .stvec_i  (stvec_i),
        .mtvec_i  (mtvec_i),
        .pc_o     (new_pc)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        if (trap_valid_i) begin
            st_d.valid = 1'b1;
            st_d.tgt   = route;
            st_d.pc    = new_pc;
            case (route)
                TGT_S: begin
                    st_d.priv   = PRIV_S;
                    st_d.scause = cause_i;
                    st_d.sepc   = epc_i;
                    st_d.stval  = tval_i;
                    st_d.spie   = sie_i;
                    st_d.spp    = cur_priv_i[0];
                    st_d.sie    = 1'b0;
                end
                TGT_M: begin
                    st_d.priv   = PRIV_M;
                    st_d.mcause = cause_i;
                    st_d.mepc   = epc_i;
                    st_d.mtval  = tval_i;
                    st_d.mpie   = mie_i;
                    st_d.mpp    = cur_priv_i;
                    st_d.mie    = 1'b0;
                end
                TGT_DBG_ENTER: begin
                    st_d.priv   = PRIV_M;
                    st_d.dcause = DCAUSE_SWBP;
                    st_d.dprv   = cur_priv_i;
                    st_d.dpc    = epc_i;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.pc   <= RESET_ADDR;
            st_q.priv <= PRIV_M;
        end else begin
            st_q <= st_d;
        end
    end

    assign redirect_valid_o = st_q.valid;
    assign target_o         = st_q.tgt;
    assign pc_o             = st_q.pc;
    assign priv_o           = st_q.priv;
    assign mcause_o         = st_q.mcause;
    assign mepc_o           = st_q.mepc;
    assign mtval_o          = st_q.mtval;
    assign scause_o         = st_q.scause;
    assign sepc_o           = st_q.sepc;
    assign stval_o          = st_q.stval;
    assign dpc_o            = st_q.dpc;
    assign dprv_o           = st_q.dprv;
    assign dcause_o         = st_q.dcause;
    assign sie_o            = st_q.sie;
    assign spie_o           = st_q.spie;
    assign spp_o            = st_q.spp;
    assign mie_o            = st_q.mie;
    assign mpie_o           = st_q.mpie;
    assign mpp_o            = st_q.mpp;

    AST_NESTED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid_i && dbg_mode_i) |=> ($stable(mcause_o) && $stable(scause_o)
            && $stable(dpc_o) && $stable(priv_o) && $stable(mie_o) && $stable(sie_o))); // R1
    AST_DBG_ENTER_M: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect_valid_o && target_o == TGT_DBG_ENTER) |-> (priv_o == PRIV_M && pc_o == DBG_ENTRY_ADDR)); // R2
    AST_NO_S_FROM_M: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid_i && !dbg_mode_i && cur_priv_i == PRIV_M) |=> (priv_o == PRIV_M)); // R4
    AST_S_ENTRY_SIE: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect_valid_o && target_o == TGT_S) |-> (!sie_o && priv_o == PRIV_S)); // R5
    AST_M_ENTRY_MIE: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect_valid_o && target_o == TGT_M) |-> (!mie_o && priv_o == PRIV_M)); // R6
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid_o |-> $past(trap_valid_i)); // R8
endmodule

// File: tb/trap_redirect_tb_top.sv
`timescale 1ns/1ps
module trap_redirect_tb_top;
    localparam logic [31:0] P_DBG_ENTRY = 32'h0000_0800;
    localparam logic [31:0] P_DBG_EXC   = 32'h0000_0808;
    localparam logic [31:0] P_RESET     = 32'h0000_1000;
    localparam logic [31:0] STVEC       = 32'h0000_2000;

    typedef struct packed {
        logic [31:0] cause;
        logic [31:0] epc;
        logic [1:0]  priv;
        logic        dbg;
        logic [2:0]  ebr;
        logic [31:0] mid;
        logic [31:0] med;
        logic [31:0] mtv;
        logic        ie;
        logic [1:0]  etgt;
        logic [31:0] epc_exp;
        logic [1:0]  epriv;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_0002, 32'h100, 2'd3, 1'b0, 3'b000, 32'h0, 32'h4,        32'h3001, 1'b1, 2'd1, 32'h3000, 2'd3},
        '{32'h8000_0007, 32'h104, 2'd3, 1'b0, 3'b000, 32'h0, 32'h0,        32'h3001, 1'b1, 2'd1, 32'h301C, 2'd3},
        '{32'h0000_0008, 32'h108, 2'd0, 1'b0, 3'b000, 32'h0, 32'h100,      32'h3001, 1'b1, 2'd0, STVEC,    2'd1},
        '{32'h8000_0005, 32'h10C, 2'd1, 1'b0, 3'b000, 32'h20, 32'h0,       32'h3001, 1'b0, 2'd0, STVEC,    2'd1},
        '{32'h8000_0005, 32'h110, 2'd1, 1'b0, 3'b000, 32'h0, 32'h20,       32'h3001, 1'b1, 2'd1, 32'h3014, 2'd3},
        '{32'h0000_0003, 32'h114, 2'd1, 1'b0, 3'b010, 32'h0, 32'h0,        32'h3001, 1'b1, 2'd2, P_DBG_ENTRY, 2'd3},
        '{32'h0000_0003, 32'h118, 2'd0, 1'b0, 3'b110, 32'h0, 32'h0,        32'h3000, 1'b0, 2'd1, 32'h3000, 2'd3},
        '{32'h0000_0003, 32'h11C, 2'd3, 1'b1, 3'b111, 32'h0, 32'h0,        32'h3001, 1'b1, 2'd3, P_DBG_ENTRY, 2'd3},
        '{32'h0000_0005, 32'h120, 2'd3, 1'b1, 3'b111, 32'h0, 32'h0,        32'h3001, 1'b1, 2'd3, P_DBG_EXC, 2'd3},
        '{32'h0000_0040, 32'h124, 2'd0, 1'b0, 3'b000, 32'h0, 32'hFFFF_FFFF, 32'h3001, 1'b1, 2'd1, 32'h3000, 2'd3},
        '{32'h8000_0003, 32'h128, 2'd3, 1'b0, 3'b111, 32'h0, 32'h0,        32'h3001, 1'b1, 2'd1, 32'h300C, 2'd3}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trap_valid_i = 1'b0;
    logic [31:0] cause_i = '0, epc_i = '0, tval_i = '0;
    logic [1:0]  cur_priv_i = 2'd3;
    logic        dbg_mode_i = 1'b0;
    logic [2:0]  ebreak_en_i = '0;
    logic [31:0] irq_deleg_i = '0, exc_deleg_i = '0, stvec_i = STVEC, mtvec_i = '0;
    logic        sie_i = 1'b0, mie_i = 1'b0;
    logic        redirect_valid_o;
    logic [1:0]  target_o, priv_o, dprv_o, mpp_o;
    logic [31:0] pc_o, mcause_o, mepc_o, mtval_o, scause_o, sepc_o, stval_o, dpc_o;
    logic [2:0]  dcause_o;
    logic        sie_o, spie_o, spp_o, mie_o, mpie_o;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    trap_redirect #(
        .DBG_ENTRY_ADDR (P_DBG_ENTRY),
        .DBG_EXC_ADDR   (P_DBG_EXC),
        .RESET_ADDR     (P_RESET)
    ) dut_i (.*);

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd0, 32'd1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] snap_m, snap_s, snap_d, snap_pc;
        logic [1:0]  snap_p;
        logic        snap_sie, snap_mie;
        repeat (3) @(negedge clk);
        // R7: reset state
        check(pc_o == P_RESET, "R7 pc", pc_o, P_RESET);
        check(priv_o == 2'd3, "R7 priv", {30'd0, priv_o}, 32'd3);
        check(!redirect_valid_o, "R7 valid", {31'd0, redirect_valid_o}, 32'd0);
        check(mcause_o == 0 && dpc_o == 0 && !mie_o, "R7 regs", mcause_o | dpc_o, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // R8: strobe low, inputs toggled, nothing moves
        cause_i = 32'h8000_0001; mtvec_i = 32'hFFFF_FFF1; exc_deleg_i = '1; cur_priv_i = 2'd0;
        @(negedge clk); @(negedge clk);
        check(pc_o == P_RESET && !redirect_valid_o && mcause_o == 0, "R8 idle hold", pc_o, P_RESET);

        for (int i = 0; i < NV; i++) begin
            snap_m = mcause_o; snap_s = scause_o; snap_d = dpc_o; snap_p = priv_o;
            snap_sie = sie_o; snap_mie = mie_o;
            cause_i = VECS[i].cause; epc_i = VECS[i].epc; tval_i = VECS[i].epc ^ 32'hA5A5_0000;
            cur_priv_i = VECS[i].priv; dbg_mode_i = VECS[i].dbg; ebreak_en_i = VECS[i].ebr;
            irq_deleg_i = VECS[i].mid; exc_deleg_i = VECS[i].med; mtvec_i = VECS[i].mtv;
            sie_i = VECS[i].ie; mie_i = VECS[i].ie;
            trap_valid_i = 1'b1;
            @(negedge clk);
            trap_valid_i = 1'b0;
            check(redirect_valid_o, "R8 valid", {31'd0, redirect_valid_o}, 32'd1);
            check(target_o == VECS[i].etgt, "R3 R4 target", {30'd0, target_o}, {30'd0, VECS[i].etgt});
            check(pc_o == VECS[i].epc_exp, "R6 R5 pc", pc_o, VECS[i].epc_exp);
            case (VECS[i].etgt)
                2'd0: begin
                    check(priv_o == 2'd1 && scause_o == VECS[i].cause && sepc_o == VECS[i].epc
                          && stval_o == (VECS[i].epc ^ 32'hA5A5_0000), "R5 S regs", scause_o, VECS[i].cause);
                    check(!sie_o && spie_o == VECS[i].ie && spp_o == VECS[i].priv[0], "R5 S status",
                          {29'd0, sie_o, spie_o, spp_o}, {30'd0, VECS[i].ie, VECS[i].priv[0]});
                end
                2'd1: begin
                    check(priv_o == 2'd3 && mcause_o == VECS[i].cause && mepc_o == VECS[i].epc
                          && mtval_o == (VECS[i].epc ^ 32'hA5A5_0000), "R6 M regs", mcause_o, VECS[i].cause);
                    check(!mie_o && mpie_o == VECS[i].ie && mpp_o == VECS[i].priv, "R6 M status",
                          {28'd0, mie_o, mpie_o, mpp_o}, {29'd0, VECS[i].ie, VECS[i].priv});
                end
                2'd2: begin
                    check(priv_o == 2'd3 && dcause_o == 3'd1 && dpc_o == VECS[i].epc && dprv_o == VECS[i].priv,
                          "R2 debug entry", dpc_o, VECS[i].epc);
                    check(mcause_o == snap_m && scause_o == snap_s, "R2 no trap regs", mcause_o, snap_m);
                end
                default: begin
                    check(mcause_o == snap_m && scause_o == snap_s && dpc_o == snap_d && priv_o == snap_p
                          && sie_o == snap_sie && mie_o == snap_mie, "R1 nested hold", mcause_o, snap_m);
                end
            endcase
            snap_pc = pc_o;
            cause_i = 32'h0000_0001; mtvec_i = 32'h0000_5001; dbg_mode_i = 1'b0;
            @(negedge clk);
            check(!redirect_valid_o && pc_o == snap_pc, "R8 one cycle pulse", pc_o, snap_pc);
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule